// File: doc/BRIEF.md
# Delay-Slot Macro Instruction Sequencer

This block fetches and steers the instruction stream of a small 32-bit macro processor. After a start pulse it reads instruction words from a synchronous instruction memory. It keeps a byte program counter and decodes the control bits of each word. For every instruction it raises a one-cycle execute strobe, so the datapath (register file and arithmetic, which sit outside this block) can act on that word. A flag on the strobe marks an instruction that runs in a delay slot.

A taken branch normally lets the next sequential word run as a delay slot before control moves to the target. With the annul bit set, that word is skipped. An exit flag also grants one delay-slot instruction, and then the run ends with a done pulse. The block raises a one-cycle error pulse and stops the run in two cases: a branch that sits in a delay slot, or a fetch beyond the loaded program length. The register value that a branch tests arrives on an input while the branch is being executed.

Each instruction takes two cycles. In the fetch cycle the block drives the read request. In the execute cycle the memory data is present and the strobe is high.

Top module: `macro_seq_top`

## Requirements
- R1: While reset is held and after its release, busy, exec_valid, exec_slot, imem_rd, done and error are all low.
- R2: A start pulse while idle begins a run at byte address 0. Each fetch reads word index pc/4 on imem_addr, and each executed instruction gives exactly one exec_valid cycle with exec_pc equal to its byte address. A non-branch is followed by the instruction at its address plus 4.
- R3: Instruction bits [4:0] hold the operation class, and class 31 is a branch. Bit 5 selects the condition: 0 takes the branch when cond_value is zero, 1 takes it when cond_value is nonzero. A branch that is not taken continues at its address plus 4.
- R4: The target of a taken branch is the branch's own byte address plus 4 times the signed word offset in bits [31:8]. Both forward and backward targets are reached.
- R5: A taken branch with the annul bit (bit 6) set skips the next sequential word. The next instruction executed is the one at the target, and it is not marked as a slot.
- R6: A taken branch with bit 6 clear lets the word at its address plus 4 execute once with exec_slot high. The target follows.
- R7: The exit flag is bit 7. On an instruction outside a delay slot, it lets the next sequential word execute with exec_slot high. After that, done is high for exactly one cycle, the cycle right after that strobe, and busy falls.
- R8: The exit flag has no effect on an instruction that executes as a delay slot.
- R9: A branch that executes as a delay slot raises error for one cycle, ends the run and produces no done.
- R10: A fetch whose word index is at or above prog_len produces no read and no strobe. Instead error is high for one cycle and the run ends without done.
- R11: A start pulse while a run is in progress has no effect on the instruction sequence.
- R12: The exit flag has no effect on a taken branch. Only the branch behaviour applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (used only when idle) |
| prog_len | input | PC_W-1 | Number of loaded instruction words |
| imem_rd | output | 1 | Instruction memory read request |
| imem_addr | output | PC_W-2 | Word index being read |
| imem_rdata | input | 32 | Instruction word, valid the cycle after the request |
| cond_value | input | 32 | Register value tested by the branch in execute |
| exec_valid | output | 1 | One-cycle strobe per executed instruction |
| exec_slot | output | 1 | Current instruction runs as a delay slot |
| exec_pc | output | PC_W | Byte address of the executed instruction |
| exec_insn | output | 32 | Executed instruction word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at a normal end of run |
| error | output | 1 | One-cycle pulse at an illegal sequence |

## Verification
The assertions check several properties on every cycle. Strobes never come back to back, and a run starts at word 0. An annulled taken branch redirects the next fetch to the target. A non-annulled taken branch, or an exit, is followed either by a slot strobe or by a stop. A branch in a slot always leads to an error and idle. Reads never go past prog_len, and done always follows a slot strobe. Other behaviours can only be shown by the bench's programs, because they depend on a whole instruction sequence. These include the order of addresses through forward and backward branches, the exit flag being ignored in slots and on taken branches, the one-cycle done timing, and immunity to a second start.

// File: rtl/macro_seq_pkg.sv
// Shared encoding constants and types for the macro sequencer.
// Assumes a 32-bit instruction word with the control fields laid out below.
package macro_seq_pkg;

    localparam int INSN_W    = 32;
    localparam int CLS_W     = 5;
    localparam int BR_CLASS  = 31;
    localparam int COND_BIT  = 5;
    localparam int ANNUL_BIT = 6;
    localparam int EXIT_BIT  = 7;
    localparam int OFF_LSB   = 8;
    localparam int OFF_W     = INSN_W - OFF_LSB;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_JUMP = 2'd1,
        PEND_STOP = 2'd2
    } pend_e;

    typedef struct packed {
        logic             is_branch;
        logic             exit_flag;
        logic             annul;
        logic             cond_nz;
        logic [OFF_W-1:0] off_words;
    } insn_dec_t;

endpackage

// File: rtl/seq_decode.sv
// Splits an instruction word into the control fields the sequencer needs.
// Assumes the field layout defined in macro_seq_pkg; purely combinational.
module seq_decode
    import macro_seq_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_dec_t         dec
);

    // Field extraction.
    always_comb begin
        dec.is_branch = (insn[CLS_W-1:0] == CLS_W'(BR_CLASS));
        dec.cond_nz   = insn[COND_BIT];
        dec.annul     = insn[ANNUL_BIT];
        dec.exit_flag = insn[EXIT_BIT];
        dec.off_words = insn[INSN_W-1:OFF_LSB];
    end

endmodule

// File: rtl/seq_branch_eval.sv
// Decides whether a branch is taken and computes its byte target.
// Assumes the target is relative to the branch's own address, offset in words.
module seq_branch_eval
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic               is_branch,
    input  logic               cond_nz,
    input  logic [OFF_W-1:0]   off_words,
    input  logic [INSN_W-1:0]  cond_value,
    input  logic [PC_W-1:0]    cur_pc,
    output logic               taken,
    output logic [PC_W-1:0]    target
);

    logic val_zero;

    // Condition test on the register value.
    always_comb begin
        val_zero = (cond_value == '0);
        taken    = is_branch && (cond_nz ? !val_zero : val_zero);
    end

    // Relative target: own address plus signed word offset scaled to bytes.
    always_comb begin
        target = cur_pc + PC_W'($signed({off_words, 2'b00}));
    end

endmodule

// File: rtl/seq_ctrl.sv
// Fetch/execute state machine with delay-slot and exit handling.
// Assumes a synchronous memory: data for a request appears one cycle later.
module seq_ctrl
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-2:0]   prog_len,
    input  logic              is_branch,
    input  logic              exit_flag,
    input  logic              annul,
    input  logic              taken,
    input  logic [PC_W-1:0]   target,
    output logic [PC_W-1:0]   pc,
    output logic              imem_rd,
    output logic              exec_valid,
    output logic              exec_slot,
    output logic              busy,
    output logic              done,
    output logic              error
);

    localparam int AW = PC_W - 2;

    seq_state_e        state;
    pend_e             pend;
    logic              in_slot;
    logic [PC_W-1:0]   pend_pc;
    logic [PC_W-1:0]   pc_next;
    logic              in_range;

    // Sequential successor and program-length check.
    always_comb begin
        pc_next  = pc + PC_W'(4);
        in_range = ({1'b0, pc[PC_W-1:2]} < prog_len);
    end

    // State, program counter and pending-action register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pc      <= '0;
            in_slot <= 1'b0;
            pend    <= PEND_NONE;
            pend_pc <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_FETCH;
                        pc      <= '0;
                        in_slot <= 1'b0;
                        pend    <= PEND_NONE;
                    end
                end
                ST_FETCH: begin
                    if (in_range) begin
                        state <= ST_EXEC;
                    end else begin
                        state <= ST_IDLE;
                        error <= 1'b1;
                    end
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    if (in_slot) begin
                        in_slot <= 1'b0;
                        pend    <= PEND_NONE;
                        if (is_branch) begin
                            state <= ST_IDLE;
                            error <= 1'b1;
                        end else if (pend == PEND_STOP) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else if (pend == PEND_JUMP) begin
                            pc <= pend_pc;
                        end else begin
                            pc <= pc_next;
                        end
                    end else if (taken) begin
                        if (annul) begin
                            pc <= target;
                        end else begin
                            pc      <= pc_next;
                            in_slot <= 1'b1;
                            pend    <= PEND_JUMP;
                            pend_pc <= target;
                        end
                    end else if (exit_flag) begin
                        pc      <= pc_next;
                        in_slot <= 1'b1;
                        pend    <= PEND_STOP;
                    end else begin
                        pc <= pc_next;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output strobes derived from state.
    always_comb begin
        busy       = (state != ST_IDLE);
        imem_rd    = (state == ST_FETCH) && in_range;
        exec_valid = (state == ST_EXEC);
        exec_slot  = (state == ST_EXEC) && in_slot;
    end

    logic [AW-1:0] unused_aw;
    // Word index width marker kept for readers of the interface.
    always_comb unused_aw = pc[PC_W-1:2];

endmodule

// File: rtl/macro_seq_top.sv
// Top of the macro instruction sequencer: decode, branch evaluation, control.
// Assumes imem_rdata holds the word requested in the previous cycle.
module macro_seq_top
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-2:0]   prog_len,
    output logic              imem_rd,
    output logic [PC_W-3:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_rdata,
    input  logic [INSN_W-1:0] cond_value,
    output logic              exec_valid,
    output logic              exec_slot,
    output logic [PC_W-1:0]   exec_pc,
    output logic [INSN_W-1:0] exec_insn,
    output logic              busy,
    output logic              done,
    output logic              error
);

    insn_dec_t       dec;
    logic            taken;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] pc;

    seq_decode u_dec (
        .insn (imem_rdata),
        .dec  (dec)
    );

    seq_branch_eval #(.PC_W(PC_W)) u_br (
        .is_branch  (dec.is_branch),
        .cond_nz    (dec.cond_nz),
        .off_words  (dec.off_words),
        .cond_value (cond_value),
        .cur_pc     (pc),
        .taken      (taken),
        .target     (target)
    );

    seq_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .prog_len   (prog_len),
        .is_branch  (dec.is_branch),
        .exit_flag  (dec.exit_flag),
        .annul      (dec.annul),
        .taken      (taken),
        .target     (target),
        .pc         (pc),
        .imem_rd    (imem_rd),
        .exec_valid (exec_valid),
        .exec_slot  (exec_slot),
        .busy       (busy),
        .done       (done),
        .error      (error)
    );

    // Port mapping of the program counter and the executed word.
    always_comb begin
        imem_addr = pc[PC_W-1:2];
        exec_pc   = pc;
        exec_insn = imem_rdata;
    end

endmodule

// File: rtl/macro_seq_chk.sv
// Cycle-level checker for macro_seq_top, attached by bind below.
// Assumes the same field layout as macro_seq_pkg.
module macro_seq_chk
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [PC_W-2:0]   prog_len,
    input logic              imem_rd,
    input logic [PC_W-3:0]   imem_addr,
    input logic [INSN_W-1:0] imem_rdata,
    input logic [INSN_W-1:0] cond_value,
    input logic              exec_valid,
    input logic              exec_slot,
    input logic [PC_W-1:0]   exec_pc,
    input logic              busy,
    input logic              done,
    input logic              error
);

    logic            c_br;
    logic            c_taken;
    logic [PC_W-1:0] c_tgt;

    // Independent view of the word under execution.
    always_comb begin
        c_br    = (imem_rdata[CLS_W-1:0] == CLS_W'(BR_CLASS));
        c_taken = c_br && (imem_rdata[COND_BIT] ? (cond_value != '0) : (cond_value == '0));
        c_tgt   = exec_pc + PC_W'($signed({imem_rdata[INSN_W-1:OFF_LSB], 2'b00}));
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !error && !exec_valid && !imem_rd));

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid);

    p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && imem_addr == '0));

    p_annul_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_slot && c_taken && imem_rdata[ANNUL_BIT])
        |=> (imem_addr == $past(c_tgt[PC_W-1:2])));

    p_slot_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_slot && c_taken && !imem_rdata[ANNUL_BIT])
        |=> ##1 (!exec_valid || exec_slot));

    p_exit_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_slot && !c_br && imem_rdata[EXIT_BIT])
        |=> ##1 (!exec_valid || exec_slot));

    p_done_after_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(exec_slot) && !busy && !error));

    p_slot_branch_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_slot && c_br) |=> (error && !busy));

    p_read_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |-> ({1'b0, imem_addr} < prog_len));

    p_error_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!exec_valid && !busy));

endmodule

bind macro_seq_top macro_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_len   (prog_len),
    .imem_rd    (imem_rd),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .cond_value (cond_value),
    .exec_valid (exec_valid),
    .exec_slot  (exec_slot),
    .exec_pc    (exec_pc),
    .busy       (busy),
    .done       (done),
    .error      (error)
);

// File: tb/sim_macro_seq_top.sv
module sim_macro_seq_top;

    localparam int PC_W  = 10;
    localparam int AW    = PC_W - 2;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [PC_W-2:0]   prog_len;
    logic              imem_rd;
    logic [AW-1:0]     imem_addr;
    logic [31:0]       imem_rdata;
    logic [31:0]       cond_value;
    logic              exec_valid;
    logic              exec_slot;
    logic [PC_W-1:0]   exec_pc;
    logic [31:0]       exec_insn;
    logic              busy;
    logic              done;
    logic              error;

    always #5 clk = ~clk;

    macro_seq_top #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_len(prog_len),
        .imem_rd(imem_rd), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .cond_value(cond_value), .exec_valid(exec_valid), .exec_slot(exec_slot),
        .exec_pc(exec_pc), .exec_insn(exec_insn), .busy(busy), .done(done),
        .error(error)
    );

    // Synchronous instruction memory model.
    logic [31:0] mem [0:DEPTH-1];
    always @(posedge clk) begin
        if (!rst_n)       imem_rdata <= '0;
        else if (imem_rd) imem_rdata <= mem[imem_addr];
    end

    int checks = 0;
    int fails  = 0;
    int cyc = 0, n = 0, done_cnt = 0, err_cnt = 0, last_exec = 0, done_at = 0;
    int   tr_pc [0:15];
    logic tr_sl [0:15];

    // Trace monitor and watchdog, sampled at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (exec_valid) begin
            if (n < 16) begin
                tr_pc[n] = int'(exec_pc);
                tr_sl[n] = exec_slot;
            end
            n++;
            last_exec = cyc;
        end
        if (done) begin
            done_cnt++;
            done_at = cyc;
        end
        if (error) err_cnt++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Fields: [31:8] offset, [7] exit, [6] annul, [5] cond, [4:0] class.
    function automatic logic [31:0] mk(input logic [4:0] cls, input logic ex,
                                       input logic an, input logic cn,
                                       input logic [23:0] off);
        return {off, ex, an, cn, cls};
    endfunction

    function automatic logic [31:0] nop(input logic ex);
        return mk(5'd1, ex, 1'b0, 1'b0, 24'd0);
    endfunction

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_trace(input string tag, input int cnt,
                             input logic [63:0] pcs, input logic [7:0] slots);
        chk_eq({tag, " count"}, n, cnt);
        for (int i = 0; i < cnt && i < n && i < 8; i++) begin
            chk_eq({tag, " pc"}, tr_pc[i], int'(pcs[i*8 +: 8]));
            chk_eq({tag, " slot"}, int'(tr_sl[i]), int'(slots[i]));
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic run(input int len, input bit extra);
        prog_len = (PC_W-1)'(len);
        n = 0; done_cnt = 0; err_cnt = 0; last_exec = 0; done_at = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (!busy) break;
            if (extra && k == 2) start = 1'b1;
            if (extra && k == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Table row: {cond_nz, annul, cond_value, count, slot mask, 5 byte pcs}.
    localparam int NV = 6;
    localparam logic [81:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 32'd0, 3'd5, 5'b10010, {8'd20, 8'd16, 8'd12, 8'd4, 8'd0}},
        {1'b0, 1'b0, 32'd5, 3'd4, 5'b01000, {8'd0,  8'd12, 8'd8,  8'd4, 8'd0}},
        {1'b1, 1'b0, 32'd5, 3'd5, 5'b10010, {8'd20, 8'd16, 8'd12, 8'd4, 8'd0}},
        {1'b1, 1'b1, 32'd5, 3'd4, 5'b01000, {8'd0,  8'd20, 8'd16, 8'd12, 8'd0}},
        {1'b1, 1'b1, 32'd0, 3'd4, 5'b01000, {8'd0,  8'd12, 8'd8,  8'd4, 8'd0}},
        {1'b0, 1'b1, 32'd0, 3'd4, 5'b01000, {8'd0,  8'd20, 8'd16, 8'd12, 8'd0}}
    };

    initial begin
        rst_n = 1'b0; start = 1'b0; prog_len = '0; cond_value = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_eq("R1 busy",  int'(busy), 0);
        chk_eq("R1 valid", int'(exec_valid), 0);
        chk_eq("R1 done",  int'(done), 0);
        chk_eq("R1 error", int'(error), 0);
        chk_eq("R1 rd",    int'(imem_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 idle after release", int'(busy), 0);

        // R2 R3 R5 R6 R7: branch condition / annul table
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            mem[0] = mk(5'd31, 1'b0, VEC[v][80], VEC[v][81], 24'd3);
            mem[1] = nop(1'b0);
            mem[2] = nop(1'b1);
            mem[3] = nop(1'b0);
            mem[4] = nop(1'b1);
            mem[5] = nop(1'b0);
            cond_value = VEC[v][79:48];
            run(6, 1'b0);
            chk_trace("R3 R5 R6 table", int'(VEC[v][47:45]),
                      {24'd0, VEC[v][39:0]}, {3'b000, VEC[v][44:40]});
            chk_eq("R7 done count", done_cnt, 1);
            chk_eq("R7 done one cycle after slot", done_at - last_exec, 1);
            chk_eq("R7 error none", err_cnt, 0);
            chk_eq("R7 busy low", int'(busy), 0);
        end

        // R4: forward then backward relative targets
        clear_mem();
        cond_value = '0;
        mem[0] = mk(5'd31, 1'b0, 1'b1, 1'b0, 24'd3);
        mem[3] = mk(5'd31, 1'b0, 1'b1, 1'b0, 24'hFFFFFE);
        mem[1] = nop(1'b1);
        mem[2] = nop(1'b0);
        run(4, 1'b0);
        chk_trace("R4 targets", 4, {32'd0, 8'd8, 8'd4, 8'd12, 8'd0}, 8'b00001000);
        chk_eq("R4 done", done_cnt, 1);

        // R11: same program with a second start mid-run
        run(4, 1'b1);
        chk_trace("R11 restart ignored", 4, {32'd0, 8'd8, 8'd4, 8'd12, 8'd0}, 8'b00001000);
        chk_eq("R11 done", done_cnt, 1);

        // R8: exit flag in a branch delay slot is ignored
        clear_mem();
        mem[0] = mk(5'd31, 1'b0, 1'b0, 1'b0, 24'd3);
        mem[1] = nop(1'b1);
        mem[2] = nop(1'b0);
        mem[3] = nop(1'b1);
        mem[4] = nop(1'b0);
        run(5, 1'b0);
        chk_trace("R8 exit in jump slot", 4, {32'd0, 8'd16, 8'd12, 8'd4, 8'd0}, 8'b00001010);
        chk_eq("R8 done", done_cnt, 1);

        // R8: exit flag in an exit slot is ignored (no fetch beyond)
        clear_mem();
        mem[0] = nop(1'b1);
        mem[1] = nop(1'b1);
        run(2, 1'b0);
        chk_trace("R8 exit in exit slot", 2, {48'd0, 8'd4, 8'd0}, 8'b00000010);
        chk_eq("R8 done", done_cnt, 1);
        chk_eq("R8 no error", err_cnt, 0);

        // R9: branch inside a delay slot
        clear_mem();
        mem[0] = nop(1'b1);
        mem[1] = mk(5'd31, 1'b0, 1'b0, 1'b0, 24'd5);
        run(8, 1'b0);
        chk_trace("R9 branch in slot", 2, {48'd0, 8'd4, 8'd0}, 8'b00000010);
        chk_eq("R9 error", err_cnt, 1);
        chk_eq("R9 no done", done_cnt, 0);

        // R10: run off the end of the program
        clear_mem();
        run(2, 1'b0);
        chk_trace("R10 past end", 2, {48'd0, 8'd4, 8'd0}, 8'b00000000);
        chk_eq("R10 error", err_cnt, 1);
        chk_eq("R10 no done", done_cnt, 0);
        run(0, 1'b0);
        chk_eq("R10 empty program strobes", n, 0);
        chk_eq("R10 empty program error", err_cnt, 1);

        // R12: exit flag on a taken annulled branch has no effect
        clear_mem();
        mem[0] = mk(5'd31, 1'b1, 1'b1, 1'b0, 24'd2);
        mem[2] = nop(1'b1);
        mem[3] = nop(1'b0);
        run(4, 1'b0);
        chk_trace("R12 exit on taken branch", 3, {40'd0, 8'd12, 8'd8, 8'd0}, 8'b00000100);
        chk_eq("R12 done", done_cnt, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule